// File: doc/BRIEF.md
# Real-Time Clock Entry Validator

This block sits between a host write port and the four holding registers of a real-time clock: current time, current calendar, time alarm and calendar alarm. Each host word carries one register's worth of BCD fields. The block checks every field of the word for BCD legality and range. For calendar words it also checks the day of the month against the length of the given month, including leap years. A word that passes every check is committed. For time words the hour is first converted to 24-hour form. A word with any bad field is dropped whole, and a sticky invalid flag for that register is raised.

A flag cannot be cleared by any control. It falls only when a later word to the same register passes every check. Two mode pins apply to each write as it is accepted. `mode_12h` selects 12-hour hour entry. `alt_cal` selects the alternate century range. The host port is valid/ready. `wr_ready` is held high, so the port applies no back-pressure and accepts one word on every clock edge where `wr_valid` is high. The committed value and the flag are visible on the cycle after acceptance.

Top module: `rtc_entry_check`

## Requirements
- R1: In a time or time-alarm word, seconds sit in bits 6:0 and minutes in bits 14:8. Each is legal only as BCD 00–59: the tens digit is at most 5 and the units digit is at most 9.
- R2: Hour sits in bits 21:16 and an AM/PM bit (1 = PM) sits in bit 22. With `mode_12h` low, the hour must be BCD 00–23 and the PM bit must be 0.
- R3: With `mode_12h` high, the hour must be BCD 01–12. It is stored as 24-hour BCD: 12 AM is stored as 00, PM hours 01–11 gain 12, and 12 PM stays 12. The stored PM bit is always 0.
- R4: In a calendar word, the century sits in bits 6:0. It must be 0x19 or 0x20 with `alt_cal` low, and 0x13 or 0x14 with `alt_cal` high.
- R5: The year in bits 15:8 must have both digits at most 9. The day of week in bits 23:21 must be 1–7.
- R6: The month in bits 20:16 must be BCD 01–12. The date in bits 29:24 must be BCD 01–31 and no larger than the month length. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4, except that year 00 is a leap year only when the century is a multiple of 4. Otherwise February has 28 days.
- R7: If any field is illegal, the target register keeps its old value and the target's flag reads 1 on the next cycle. Targets are selected by `wr_target`: 0 time, 1 calendar, 2 time alarm, 3 calendar alarm.
- R8: A flag clears only on a fully legal write to its own target. Idle cycles and writes to other targets leave every other flag and register unchanged.
- R9: The time alarm uses the time rules (R1–R3). The calendar alarm checks only month and date, and always allows February 29. Its stored word holds only bits 20:16 and 29:24.
- R10: `wr_ready` is always 1, so writes on consecutive cycles are all taken. Unused bits are stored as 0. After reset, time and time alarm read 0, calendar reads 0x01210020, calendar alarm reads 0x01010000, and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_12h | input | 1 | 1 = hours are entered in 12-hour form |
| alt_cal | input | 1 | 1 = alternate century range 13/14 |
| wr_valid | input | 1 | Host word present |
| wr_ready | output | 1 | Always 1; the port never stalls |
| wr_target | input | 2 | Destination register select |
| wr_data | input | 32 | BCD field word |
| time_q | output | 32 | Committed time, 24-hour |
| cal_q | output | 32 | Committed calendar |
| talm_q | output | 32 | Committed time alarm |
| calm_q | output | 32 | Committed calendar alarm |
| bad_time | output | 1 | Sticky invalid flag, time |
| bad_cal | output | 1 | Sticky invalid flag, calendar |
| bad_talm | output | 1 | Sticky invalid flag, time alarm |
| bad_calm | output | 1 | Sticky invalid flag, calendar alarm |

## Verification
The state in this block is only the four committed words and their flags. Any wrong decision therefore shows at the ports on the very cycle after the offending write: a flag level that does not match, or a register that moved when it should have held. A wrong leap or month-length rule appears only at specific month and date pairs. For that reason the bench sweeps every month and date code against leap, non-leap and century years. Errors in the hour conversion show as a wrong stored hour even when the flag is correct, so the stored word is compared on every write.

// File: rtl/rtc_entry_pkg.sv
package rtc_entry_pkg;
  localparam int WORD_W  = 32;
  localparam int N_TGT   = 4;
  localparam int TGT_W   = $clog2(N_TGT);

  // Field positions in the host word
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int PM_BIT   = 22;
  localparam int CEN_LSB  = 0;
  localparam int YR_LSB   = 8;
  localparam int MON_LSB  = 16;
  localparam int WDAY_LSB = 21;
  localparam int DATE_LSB = 24;

  typedef enum logic [TGT_W-1:0] {
    TGT_TIME = 2'd0,
    TGT_CAL  = 2'd1,
    TGT_TALM = 2'd2,
    TGT_CALM = 2'd3
  } tgt_e;

  function automatic logic digit_ok(input logic [3:0] d);
    return d <= 4'd9;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [3:0] t, input logic [3:0] u);
    return ({4'b0, t} << 3) + ({4'b0, t} << 1) + {4'b0, u};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    logic [7:0] r;
    case (mon)
      8'd2:                       r = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    r = 8'd30;
      default:                    r = 8'd31;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(input int idx);
    logic [WORD_W-1:0] r;
    case (idx)
      1:       r = 32'h0121_0020;
      3:       r = 32'h0101_0000;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_time_chk.sv
module rtc_time_chk
  import rtc_entry_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              mode_12h_i,
  output logic              ok_o,
  output logic [WORD_W-1:0] norm_o
);
  logic [6:0] sec, mins;
  logic [5:0] hr;
  logic       pm;
  logic [7:0] hr_bin, h24;
  logic [3:0] h_tens, h_units;
  logic       sec_ok, min_ok, h24_ok, h12_ok;
  logic       unused_bits;

  assign sec  = word_i[SEC_LSB +: 7];
  assign mins = word_i[MIN_LSB +: 7];
  assign hr   = word_i[HR_LSB +: 6];
  assign pm   = word_i[PM_BIT];
  assign unused_bits = ^{word_i[WORD_W-1:PM_BIT+1], word_i[HR_LSB-1:MIN_LSB+7],
                         word_i[MIN_LSB-1:SEC_LSB+7]};

  assign sec_ok = (sec[6:4] <= 3'd5) && digit_ok(sec[3:0]);
  assign min_ok = (mins[6:4] <= 3'd5) && digit_ok(mins[3:0]);

  assign hr_bin = bcd_to_bin({2'b00, hr[5:4]}, hr[3:0]);
  assign h24_ok = !pm && digit_ok(hr[3:0]) && (hr_bin <= 8'd23);
  assign h12_ok = digit_ok(hr[3:0]) && (hr_bin >= 8'd1) && (hr_bin <= 8'd12);

  assign ok_o = sec_ok && min_ok && (mode_12h_i ? h12_ok : h24_ok);

  always_comb begin
    if (!mode_12h_i)      h24 = hr_bin;
    else if (pm)          h24 = (hr_bin == 8'd12) ? 8'd12 : hr_bin + 8'd12;
    else                  h24 = (hr_bin == 8'd12) ? 8'd0  : hr_bin;
  end

  always_comb begin
    if (h24 >= 8'd20)      h_tens = 4'd2;
    else if (h24 >= 8'd10) h_tens = 4'd1;
    else                   h_tens = 4'd0;
    h_units = 4'(h24 - bcd_to_bin(h_tens, 4'd0));
  end

  always_comb begin
    norm_o = '0;
    norm_o[SEC_LSB +: 7] = sec;
    norm_o[MIN_LSB +: 7] = mins;
    norm_o[HR_LSB +: 6]  = {h_tens[1:0], h_units};
  end
endmodule

// File: rtl/rtc_date_chk.sv
module rtc_date_chk
  import rtc_entry_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              alt_cal_i,
  output logic              ok_o,
  output logic [WORD_W-1:0] norm_o
);
  logic [4:0] mon;
  logic [5:0] dt;
  logic [7:0] mon_bin, dt_bin;
  logic       mon_ok, dt_ok, rest_ok, leap;

  assign mon = word_i[MON_LSB +: 5];
  assign dt  = word_i[DATE_LSB +: 6];

  assign mon_bin = bcd_to_bin({3'b000, mon[4]}, mon[3:0]);
  assign dt_bin  = bcd_to_bin({2'b00, dt[5:4]}, dt[3:0]);
  assign mon_ok  = digit_ok(mon[3:0]) && (mon_bin >= 8'd1) && (mon_bin <= 8'd12);
  assign dt_ok   = digit_ok(dt[3:0]) && (dt_bin >= 8'd1) &&
                   (dt_bin <= month_len(mon_bin, leap));

  generate
    if (FULL) begin : g_full
      logic [6:0] cen;
      logic [7:0] yr, yr_bin, cen_bin;
      logic [2:0] wday;
      logic       cen_ok, unused_bits;
      assign cen  = word_i[CEN_LSB +: 7];
      assign yr   = word_i[YR_LSB +: 8];
      assign wday = word_i[WDAY_LSB +: 3];
      assign unused_bits = ^{word_i[WORD_W-1:DATE_LSB+6], word_i[CEN_LSB+7]};
      assign yr_bin  = bcd_to_bin(yr[7:4], yr[3:0]);
      assign cen_bin = bcd_to_bin({1'b0, cen[6:4]}, cen[3:0]);
      assign cen_ok  = alt_cal_i ? (cen == 7'h13 || cen == 7'h14)
                                 : (cen == 7'h19 || cen == 7'h20);
      assign rest_ok = cen_ok && digit_ok(yr[7:4]) && digit_ok(yr[3:0]) && (wday != 3'd0);
      assign leap    = (yr_bin[1:0] == 2'b00) &&
                       ((yr_bin != 8'd0) || (cen_bin[1:0] == 2'b00));
      always_comb begin
        norm_o = '0;
        norm_o[CEN_LSB +: 7]  = cen;
        norm_o[YR_LSB +: 8]   = yr;
        norm_o[MON_LSB +: 5]  = mon;
        norm_o[WDAY_LSB +: 3] = wday;
        norm_o[DATE_LSB +: 6] = dt;
      end
    end else begin : g_alarm
      logic unused_bits;
      assign unused_bits = ^{word_i[WORD_W-1:DATE_LSB+6], word_i[DATE_LSB-1:MON_LSB+5],
                             word_i[MON_LSB-1:0], alt_cal_i};
      assign rest_ok = 1'b1;
      assign leap    = 1'b1;
      always_comb begin
        norm_o = '0;
        norm_o[MON_LSB +: 5]  = mon;
        norm_o[DATE_LSB +: 6] = dt;
      end
    end
  endgenerate

  assign ok_o = mon_ok && dt_ok && rest_ok;
endmodule

// File: rtl/rtc_hold_reg.sv
module rtc_hold_reg
  import rtc_entry_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              ok_i,
  input  logic [WORD_W-1:0] norm_i,
  output logic [WORD_W-1:0] q_o,
  output logic              bad_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= RESET_VAL;
      bad_o <= 1'b0;
    end else if (we_i) begin
      if (ok_i) begin
        q_o   <= norm_i;
        bad_o <= 1'b0;
      end else begin
        bad_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_entry_check.sv
module rtc_entry_check
  import rtc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_12h,
  input  logic              alt_cal,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [TGT_W-1:0]  wr_target,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] time_q,
  output logic [WORD_W-1:0] cal_q,
  output logic [WORD_W-1:0] talm_q,
  output logic [WORD_W-1:0] calm_q,
  output logic              bad_time,
  output logic              bad_cal,
  output logic              bad_talm,
  output logic              bad_calm
);
  logic [N_TGT-1:0]  ok_vec, bad_vec, we_vec;
  logic [WORD_W-1:0] norm_arr [N_TGT];
  logic [WORD_W-1:0] q_arr    [N_TGT];

  assign wr_ready = 1'b1;

  generate
    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
      assign we_vec[g] = wr_valid && wr_ready && (wr_target == TGT_W'(g));
      if ((g % 2) == 0) begin : g_time
        rtc_time_chk u_chk (
          .word_i     (wr_data),
          .mode_12h_i (mode_12h),
          .ok_o       (ok_vec[g]),
          .norm_o     (norm_arr[g])
        );
      end else begin : g_date
        rtc_date_chk #(.FULL(g < 2)) u_chk (
          .word_i    (wr_data),
          .alt_cal_i (alt_cal),
          .ok_o      (ok_vec[g]),
          .norm_o    (norm_arr[g])
        );
      end
      rtc_hold_reg #(.RESET_VAL(reset_word(g))) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we_vec[g]),
        .ok_i   (ok_vec[g]),
        .norm_i (norm_arr[g]),
        .q_o    (q_arr[g]),
        .bad_o  (bad_vec[g])
      );
    end
  endgenerate

  assign time_q   = q_arr[TGT_TIME];
  assign cal_q    = q_arr[TGT_CAL];
  assign talm_q   = q_arr[TGT_TALM];
  assign calm_q   = q_arr[TGT_CALM];
  assign bad_time = bad_vec[TGT_TIME];
  assign bad_cal  = bad_vec[TGT_CAL];
  assign bad_talm = bad_vec[TGT_TALM];
  assign bad_calm = bad_vec[TGT_CALM];
endmodule

// File: rtl/rtc_entry_sva.sv
module rtc_entry_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [1:0]  wr_target,
  input logic        time_ok,
  input logic        cal_ok,
  input logic [31:0] time_q,
  input logic [31:0] cal_q,
  input logic        bad_time,
  input logic        bad_cal
);
  logic wr_t, wr_c;
  assign wr_t = wr_valid && (wr_target == 2'd0);
  assign wr_c = wr_valid && (wr_target == 2'd1);

  AST_TIME_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t && !time_ok |=> bad_time && $stable(time_q)); // R7
  AST_CAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c && !cal_ok |=> bad_cal && $stable(cal_q)); // R7
  AST_TIME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t && time_ok |=> !bad_time); // R8
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_t |=> $stable(bad_time) && $stable(time_q)); // R8
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> $stable(bad_cal) && $stable(cal_q)); // R8
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q[21:16] <= 6'h23) && (time_q[19:16] <= 4'd9) && !time_q[22]); // R2
  AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q[29:24] != 6'h00) && (cal_q[29:24] <= 6'h31) && (cal_q[27:24] <= 4'd9)); // R6
endmodule

bind rtc_entry_check rtc_entry_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_target (wr_target),
  .time_ok   (ok_vec[0]),
  .cal_ok    (ok_vec[1]),
  .time_q    (time_q),
  .cal_q     (cal_q),
  .bad_time  (bad_time),
  .bad_cal   (bad_cal)
);

// File: tb/sim_rtc_entry_check.sv
module sim_rtc_entry_check;
  logic clk = 1'b0, rst_n = 1'b0, mode_12h = 1'b0, alt_cal = 1'b0, wr_valid = 1'b0;
  logic [1:0]  wr_target = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic [31:0] time_q, cal_q, talm_q, calm_q;
  logic        bad_time, bad_cal, bad_talm, bad_calm;
  int checks = 0, errors = 0;
  logic [31:0] m_q [4];
  logic        m_bad [4];

  always #2.5 clk = ~clk;

  rtc_entry_check u0 (.*);

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int dec(int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction
  function automatic bit bcdok(int b);
    return ((b & 15) < 10) && ((b >> 4) < 10);
  endfunction
  function automatic int mlen(int m, bit lp);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic bit time_exp(logic [31:0] w, bit m12, output logic [31:0] n);
    int s = w & 127, mi = (w >> 8) & 127, h = (w >> 16) & 63, pm = (w >> 22) & 1;
    int hd = dec(h), h24;
    bit ok = bcdok(s) && dec(s) <= 59 && bcdok(mi) && dec(mi) <= 59 && bcdok(h);
    if (m12) begin
      ok = ok && hd >= 1 && hd <= 12;
      h24 = pm ? (hd == 12 ? 12 : hd + 12) : (hd == 12 ? 0 : hd);
    end else begin
      ok = ok && hd <= 23 && pm == 0;
      h24 = hd;
    end
    n = s | (mi << 8) | (((h24 / 10) * 16 + h24 % 10) << 16);
    return ok;
  endfunction

  function automatic bit cal_exp(logic [31:0] w, bit alt, bit full, output logic [31:0] n);
    int c = w & 127, y = (w >> 8) & 255, mo = (w >> 16) & 31, wd = (w >> 21) & 7, d = (w >> 24) & 63;
    bit lp = 1, ok;
    if (full) lp = (dec(y) % 4 == 0) && (dec(y) != 0 || dec(c) % 4 == 0);
    ok = bcdok(mo) && dec(mo) >= 1 && dec(mo) <= 12 && bcdok(d) && dec(d) >= 1 &&
         dec(d) <= mlen(dec(mo), lp);
    if (full) begin
      ok = ok && (alt ? (c == 'h13 || c == 'h14) : (c == 'h19 || c == 'h20)) && bcdok(y) && wd != 0;
      n = w & 32'h3FFF_FF7F;
    end else n = w & 32'h3F1F_0000;
    return ok;
  endfunction

  task automatic check(bit cond, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [31:0] q [4] = '{time_q, cal_q, talm_q, calm_q};
    logic        b [4] = '{bad_time, bad_cal, bad_talm, bad_calm};
    for (int i = 0; i < 4; i++) begin
      check(q[i] === m_q[i], req, q[i], m_q[i]);
      check(b[i] === m_bad[i], req, 32'(b[i]), 32'(m_bad[i]));
    end
  endtask

  // expected model update for one accepted word
  task automatic model(int tgt, logic [31:0] w);
    logic [31:0] n;
    bit ok = (tgt % 2 == 0) ? time_exp(w, mode_12h, n) : cal_exp(w, alt_cal, tgt == 1, n);
    if (ok) begin m_q[tgt] = n; m_bad[tgt] = 0; end
    else m_bad[tgt] = 1;
  endtask

  task automatic wr(int tgt, logic [31:0] w, string req);
    @(negedge clk);
    wr_valid = 1; wr_target = 2'(tgt); wr_data = w;
    check(wr_ready === 1'b1, "R10", 32'(wr_ready), 1);
    model(tgt, w);
    @(negedge clk);
    wr_valid = 0;
    check_all(req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_q[i] = '0; m_bad[i] = 0; end
    m_q[1] = 32'h0121_0020; m_q[3] = 32'h0101_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R10 reset");

    // R2: 24-hour sweep of hour and PM bit
    for (int pm = 0; pm < 2; pm++)
      for (int h = 0; h < 64; h++) wr(0, (pm << 22) | (h << 16) | 32'h3459, "R2");
    // R3: 12-hour sweep with conversion
    mode_12h = 1;
    for (int pm = 0; pm < 2; pm++)
      for (int h = 0; h < 64; h++) wr(0, (pm << 22) | (h << 16) | 32'h0712, "R3");
    mode_12h = 0;
    // R1: seconds and minutes codes
    for (int v = 0; v < 128; v++) wr(0, 32'h0011_0000 | v, "R1 sec");
    for (int v = 0; v < 128; v++) wr(0, 32'h0011_0000 | (v << 8), "R1 min");
    // R4: century in both modes
    for (int a = 0; a < 2; a++) begin
      alt_cal = a[0];
      for (int c = 0; c < 128; c++) wr(1, 32'h1565_2300 | c, "R4");
    end
    alt_cal = 0;
    // R5: year codes and weekday codes
    for (int y = 0; y < 256; y++) wr(1, 32'h1545_0020 | (y << 8), "R5 year");
    for (int d = 0; d < 8; d++) wr(1, 32'h1505_2320 | (d << 21), "R5 wday");
    // R6: month x date against leap and non-leap years
    for (int k = 0; k < 4; k++) begin
      int cy [4] = '{'h20_00, 'h19_00, 'h20_24, 'h20_23};
      for (int mo = 0; mo < 32; mo++)
        for (int d = 0; d < 64; d++)
          wr(1, (d << 24) | (3 << 21) | (mo << 16) | ((cy[k] & 255) << 8) | (cy[k] >> 8), "R6");
    end
    // R9: alarms
    for (int h = 0; h < 64; h++) wr(2, (h << 16) | 32'h0000_5900, "R9 talm");
    for (int mo = 0; mo < 32; mo++)
      for (int d = 0; d < 64; d++) wr(3, (d << 24) | (mo << 16) | 32'h00E0_FFFF, "R9 calm");
    // R8: sticky flags, other targets and idle cycles leave them alone
    wr(0, 32'h0024_0000, "R8 set");
    wr(2, 32'h0000_6000, "R8 set");
    wr(1, 32'h0125_2320, "R8 other");
    wr(3, 32'h0102_0000, "R8 other");
    repeat (5) @(negedge clk);
    check_all("R8 idle");
    wr(0, 32'h0023_5959, "R8 clear");
    wr(2, 32'h0000_0000, "R8 clear");
    // R7: bad word after good keeps old value
    wr(1, 32'h3022_2420, "R7");
    wr(1, 32'h2922_2420, "R7");
    // R10: back-to-back writes, last one wins
    @(negedge clk);
    wr_valid = 1; wr_target = 2'd0; wr_data = 32'h0010_1010; model(0, wr_data);
    @(negedge clk);
    wr_data = 32'h0045_0000; model(0, wr_data);
    @(negedge clk);
    wr_data = 32'h0021_2223; model(0, wr_data);
    @(negedge clk);
    wr_valid = 0;
    check_all("R10 burst");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule